// File: doc/BRIEF.md
# Byte-Masked Streaming Store Unit

This unit turns one store operation into at most one memory write. An operation carries a 64-bit data word, a 64-bit mask word and a target address. The address comes in on its own input and never passes through the data path. The most significant bit of each mask byte decides whether the matching data byte is written. The unit captures the operation and presents a single write request on a request/ready interface. That request carries the address, the full data word and eight byte enables. The request stays frozen until the memory side takes it.

The store does not allocate into any cache, and it carries no ordering guarantee against other traffic. When no mask byte has its top bit set, the unit completes the operation at once and raises no memory request. A separate combinational output collects the same top bits into an 8-bit value, zero-extended to 32 bits, so that a caller can branch on the mask.

The controller has three states. In `ST_IDLE` it waits for work. In `ST_WRITE` it holds a pending write request. `ST_DONE` lasts one cycle and signals completion. Its transitions are:

- `ST_IDLE`/`ST_DONE` → `ST_WRITE` when an operation with at least one enabled byte is accepted.
- `ST_IDLE`/`ST_DONE` → `ST_DONE` when an operation with no enabled byte is accepted.
- `ST_WRITE` → `ST_DONE` on the cycle where request and ready are both high.
- `ST_DONE` → `ST_IDLE` when nothing new arrives.

Top module: `bytemask_store`

## Requirements
- R1: Enable bit i of `mem_be` equals bit 8*i+7 of the accepted `op_mask`, with byte 0 the least significant byte.
- R2: `mem_addr` and `mem_wdata` equal the `op_addr` and the full `op_data` of the accepted operation, whatever the enables are.
- R3: `mask_bits[7:0]` bit i equals `op_mask[8*i+7]` combinationally, and `mask_bits[31:8]` is zero.
- R4: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high on the next cycle and `mem_addr`, `mem_wdata` and `mem_be` are unchanged.
- R5: An accepted operation whose mask has no top bit set raises no `mem_req`. `op_done` is high in the next cycle and `busy` stays low.
- R6: `busy` is high from the cycle after an accept that needs a write until the handshake cycle. An `op_valid` seen while `busy` is high is ignored, so no write for it ever appears.
- R7: `op_done` is a one-cycle pulse in the cycle after the handshake, and `mem_req` and `busy` are low in that cycle.
- R8: After reset, `mem_req`, `busy` and `op_done` are low.
- R9: A `mem_req` never carries an all-zero `mem_be`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present; taken when `busy` is low |
| op_data | input | 64 | Data operand |
| op_mask | input | 64 | Mask operand; the top bit of each byte enables that byte |
| op_addr | input | 48 | Target address |
| mask_bits | output | 32 | Top bits of the mask bytes, zero-extended |
| busy | output | 1 | Write pending; new operations are refused |
| op_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 48 | Write address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables |

## Verification
The bench aims at four corner cases:

- **Mask words whose only set bits are below bit 7 of each byte.** A design that read the wrong bit of a byte would enable bytes here, or would issue a write for a mask that should be silent.
- **Fully zero top bits.** A design that sent a write with no enables, or that stalled in the busy state, fails this case.
- **Random ready stalls.** These expose a request that drifts or drops before it is taken.
- **Operations offered while busy.** A design that accepted them would overwrite the pending write or emit an extra one after the handshake.

// File: rtl/bms_pkg.sv
package bms_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } bms_state_e;
endpackage

// File: rtl/bms_mask_extract.sv
module bms_mask_extract #(
    parameter int NBYTES = 8,
    parameter int EXT_W  = 32
) (
    input  logic [NBYTES*8-1:0] mask,
    output logic [NBYTES-1:0]   enables,
    output logic [EXT_W-1:0]    packed_bits
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign enables[i] = mask[8*i+7];
    end

    assign packed_bits = {{(EXT_W-NBYTES){1'b0}}, enables};
endmodule

// File: rtl/bms_ctrl.sv
module bms_ctrl
    import bms_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int ADDR_W = 48,
    localparam int DATA_W = NBYTES*8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] op_data,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [NBYTES-1:0] op_be,
    output logic              busy,
    output logic              op_done,
    output logic              mem_req,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NBYTES-1:0] mem_be
);
    bms_state_e state_q, state_d;
    logic       accept;
    logic       any_be;

    assign any_be = |op_be;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        busy    = 1'b0;
        op_done = 1'b0;
        mem_req = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                op_done = (state_q == ST_DONE);
                accept  = op_valid;
                if (op_valid) state_d = any_be ? ST_WRITE : ST_DONE;
                else          state_d = ST_IDLE;
            end
            ST_WRITE: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                if (mem_ready) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // captured write request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_wdata <= '0;
            mem_be    <= '0;
        end else if (accept && any_be) begin
            mem_addr  <= op_addr;
            mem_wdata <= op_data;
            mem_be    <= op_be;
        end
    end

    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_be)));

    a_r9_nonzero_be: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be != '0));

    a_r7_done_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready) |=> (op_done && !busy && !mem_req));

    a_r5_silent_complete: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && !any_be) |=> (op_done && !mem_req && !busy));

    a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> busy);
endmodule

// File: rtl/bytemask_store.sv
module bytemask_store #(
    parameter int NBYTES = 8,
    parameter int ADDR_W = 48,
    parameter int EXT_W  = 32,
    localparam int DATA_W = NBYTES*8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [DATA_W-1:0] op_data,
    input  logic [DATA_W-1:0] op_mask,
    input  logic [ADDR_W-1:0] op_addr,
    output logic [EXT_W-1:0]  mask_bits,
    output logic              busy,
    output logic              op_done,
    output logic              mem_req,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NBYTES-1:0] mem_be
);
    logic [NBYTES-1:0] be_sel;

    bms_mask_extract #(.NBYTES(NBYTES), .EXT_W(EXT_W)) u_extract (
        .mask        (op_mask),
        .enables     (be_sel),
        .packed_bits (mask_bits)
    );

    bms_ctrl #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_data   (op_data),
        .op_addr   (op_addr),
        .op_be     (be_sel),
        .busy      (busy),
        .op_done   (op_done),
        .mem_req   (mem_req),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_be    (mem_be)
    );

    a_r3_extract_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mask_bits[EXT_W-1:NBYTES] == '0);
endmodule

// File: tb/tb_bytemask_store.sv
module tb_bytemask_store;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [63:0] op_data = '0;
    logic [63:0] op_mask = '0;
    logic [47:0] op_addr = '0;
    logic [31:0] mask_bits;
    logic        busy, op_done, mem_req;
    logic        mem_ready = 1'b0;
    logic [47:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_be;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bytemask_store dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_data(op_data),
        .op_mask(op_mask), .op_addr(op_addr), .mask_bits(mask_bits),
        .busy(busy), .op_done(op_done), .mem_req(mem_req),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be)
    );

    function automatic logic [7:0] exp_be(input logic [63:0] m);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = m[8*i+7];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] d, input logic [63:0] m,
                          input logic [47:0] a, input int stall);
        logic [7:0] be;
        be = exp_be(m);
        @(negedge clk);
        op_valid = 1'b1; op_data = d; op_mask = m; op_addr = a;
        #1;
        check("R3 mask_bits", {32'd0, mask_bits}, {56'd0, be});
        @(posedge clk);
        @(negedge clk);
        // offer a junk operation while busy
        op_valid = 1'b1; op_data = ~d; op_mask = 64'hFFFF_FFFF_FFFF_FFFF; op_addr = ~a;
        if (be == 8'd0) begin
            op_valid = 1'b0;
            check("R5 no request", {63'd0, mem_req}, 64'd0);
            check("R5 done", {63'd0, op_done}, 64'd1);
            check("R5 busy low", {63'd0, busy}, 64'd0);
            return;
        end
        check("R1 enables", {56'd0, mem_be}, {56'd0, be});
        check("R2 addr", {16'd0, mem_addr}, {16'd0, a});
        check("R2 data", mem_wdata, d);
        check("R6 busy", {63'd0, busy}, 64'd1);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check("R4 req held", {63'd0, mem_req}, 64'd1);
            check("R4 data held", mem_wdata, d);
            check("R4 enables held", {56'd0, mem_be}, {56'd0, be});
            check("R6 ignored while busy", {16'd0, mem_addr}, {16'd0, a});
        end
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
        op_valid = 1'b0;
        check("R7 done pulse", {63'd0, op_done}, 64'd1);
        check("R7 req low", {63'd0, mem_req}, 64'd0);
        check("R7 busy low", {63'd0, busy}, 64'd0);
        @(negedge clk);
        check("R7 done one cycle", {63'd0, op_done}, 64'd0);
        check("R6 no extra write", {63'd0, mem_req}, 64'd0);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R8 req reset", {63'd0, mem_req}, 64'd0);
        check("R8 busy reset", {63'd0, busy}, 64'd0);
        check("R8 done reset", {63'd0, op_done}, 64'd0);
        rst_n = 1'b1;
        // directed corners
        run_op(64'h0123_4567_89AB_CDEF, 64'h7F7F_7F7F_7F7F_7F7F, 48'h1000, 0);
        run_op(64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_0000, 48'h2000, 0);
        run_op(64'h1111_2222_3333_4444, 64'h8000_0000_0000_0080, 48'hABC, 3);
        run_op(64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFF8, 0);
        run_op(64'h5555_AAAA_5555_AAAA, 64'h0080_0000_0000_0000, 48'h40, 5);
        for (int n = 0; n < 60; n++) begin
            logic [63:0] d, m;
            logic [47:0] a;
            d = {$urandom, $urandom};
            m = {$urandom, $urandom};
            if ($urandom_range(0, 4) == 0) m = m & 64'h7F7F_7F7F_7F7F_7F7F;
            a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFF8;
            run_op(d, m, a, $urandom_range(0, 3));
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule